// File: doc/BRIEF.md
# Shadow-Buffered Multi-Mode PWM Generator

This block is a single-channel PWM timer with two outputs. A period counter runs in one of three modes. Counting up or counting down gives edge-aligned pulses. Counting up and then down gives pulses centred in the period. Two compare values, A and B, set the duty cycle of outputs `pwm_a` and `pwm_b`.

All settings arrive through one write port: a select code, a data word and a write strobe. Each compare value has its own buffering switch. With buffering on, a new value waits in a holding register and moves to the active register at the start of the next period, so a change made mid-period never cuts or stretches a pulse. With buffering off, the value takes effect on the next clock. In that case one period with an intermediate duty cycle is accepted. The period value always goes through the holding register and loads at the same start-of-period point as the compare values.

A clock-enable input sets the counting rate. While it is low, the counter, the outputs and the start-of-period loads are frozen, but writes are still captured.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After synchronous reset the counter is 0, the mode is up-count, both buffering switches are on, period and compare values are 0, and both outputs are low.
- R2: Up-count mode (mode code 0): the counter steps 0,1,…,P and wraps to 0, giving P+1 ticks per period. An output is high while count < its compare value, so both outputs rise together at the start of the period.
- R3: Down-count mode (mode code 1): the counter steps P,P-1,…,0 and reloads P, giving P+1 ticks per period. An output is high while count < its compare value, so both outputs fall together.
- R4: Up-down mode (mode code 2 or 3): the counter steps 0,1,…,P,P-1,…,1, giving 2P ticks per period. An output is high while count >= its compare value, so pulses are centred on the count P.
- R5: A compare value of 0 holds its output low for the whole period. A nonzero compare value >= P holds its output high for the whole period. Both rules override R2 to R4.
- R6: With buffering on, a compare write lands only in the holding register. The active value is unchanged until the load point: count 0 in up-count and up-down modes, count P in down-count mode. The loaded value already governs the output for the load tick.
- R7: With buffering off, a compare write replaces the active value on the next clock, even mid-period.
- R8: Writing select code 4 sets the buffering switches: data bit 0 for compare A, data bit 1 for compare B. Each switch acts only on its own compare value.
- R9: When the holding register is written several times before a load point, only the last value reaches the active register.
- R10: A period write (select code 0) is always buffered and loads at the same load point as the compare values.
- R11: While `cnt_en` is low, the counter, the outputs and all loads hold still; writes are still captured.
- R12: Write select codes: 0 period, 1 compare A, 2 compare B, 3 mode (data bits 1:0), 4 buffering switches. A mode write restarts the counter at 0, or at the active period for down-count, counting upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter tick enable |
| wr_en | input | 1 | Write strobe for the setting port |
| wr_sel | input | 3 | Setting select code (see R12) |
| wr_data | input | CNT_W | Write data |
| pwm_a | output | 1 | Registered output driven by compare A |
| pwm_b | output | 1 | Registered output driven by compare B |

## Verification
The assertions assume that `wr_sel` carries only codes 0 to 4 while `wr_en` is high. They also assume that reset is held for at least one clock before the first write. The stimulus writes only the five defined codes, and it issues every write as a one-cycle strobe aligned to the falling clock edge. Duty cycles are measured only after enough cycles have passed for two full periods to complete since the last setting change. This keeps each measured window clear of restart or load transients.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  typedef enum logic [1:0] {
    CM_UP   = 2'd0,
    CM_DOWN = 2'd1,
    CM_UPDN = 2'd2
  } cnt_mode_e;

  localparam int SEL_W   = 3;
  localparam int NUM_CMP = 2;

  localparam logic [SEL_W-1:0] SEL_PRD  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CMPA = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CMPB = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MODE = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SHEN = 3'd4;

  function automatic cnt_mode_e decode_mode(input logic [1:0] code);
    cnt_mode_e m;
    if (code[1])      m = CM_UPDN;
    else if (code[0]) m = CM_DOWN;
    else              m = CM_UP;
    return m;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  cnt_mode_e        mode,
  input  cnt_mode_e        restart_mode,
  input  logic [CNT_W-1:0] prd_act,
  input  logic [CNT_W-1:0] prd_nxt,
  output logic [CNT_W-1:0] cnt,
  output logic             load_pt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dir_up;
  logic [CNT_W-1:0] cnt_d;
  logic             dir_d;

  always_comb begin
    if (mode == CM_DOWN) load_pt = tick && !restart && (cnt == prd_act);
    else                 load_pt = tick && !restart && (cnt == '0);
  end

  always_comb begin
    cnt_d = cnt;
    dir_d = dir_up;
    if (restart) begin
      cnt_d = (restart_mode == CM_DOWN) ? prd_act : '0;
      dir_d = 1'b1;
    end else if (tick) begin
      case (mode)
        CM_UP: begin
          cnt_d = (cnt >= prd_nxt) ? '0 : cnt + ONE;
        end
        CM_DOWN: begin
          cnt_d = (cnt == '0) ? prd_nxt : cnt - ONE;
        end
        default: begin
          if (dir_up) begin
            if (cnt >= prd_nxt) begin
              if (cnt != '0) begin
                cnt_d = cnt - ONE;
                dir_d = 1'b0;
              end
            end else begin
              cnt_d = cnt + ONE;
            end
          end else begin
            if (cnt == '0) begin
              dir_d = 1'b1;
              cnt_d = (prd_nxt == '0) ? '0 : ONE;
            end else begin
              cnt_d = cnt - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      cnt    <= cnt_d;
      dir_up <= dir_d;
    end
  end

endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int             W       = 16,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         shadow_en,
  input  logic         load,
  output logic [W-1:0] active,
  output logic [W-1:0] nxt
);

  logic [W-1:0] hold_q;

  // value the active register takes at a load tick, visible in that tick
  assign nxt = load ? hold_q : active;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= RST_VAL;
      active <= RST_VAL;
    end else begin
      if (wr) hold_q <= wr_data;
      if (wr && !shadow_en) active <= wr_data;
      else if (load)        active <= hold_q;
    end
  end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] prd,
  output logic             pwm
);

  logic lvl;

  always_comb begin
    if (cmp == '0)       lvl = 1'b0;
    else if (cmp >= prd) lvl = 1'b1;
    else begin
      case (mode)
        CM_UP, CM_DOWN: lvl = (cnt < cmp);
        default:        lvl = (cnt >= cmp);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       pwm <= 1'b0;
    else if (tick) pwm <= lvl;
  end

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter int             CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_PRD = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_a,
  output logic             pwm_b
);

  cnt_mode_e            mode_q;
  cnt_mode_e            mode_new;
  logic [NUM_CMP-1:0]   shen_q;
  logic                 mode_wr;
  logic                 prd_wr;
  logic [CNT_W-1:0]     cnt_q;
  logic                 load_pt;
  logic [CNT_W-1:0]     prd_act;
  logic [CNT_W-1:0]     prd_nxt;
  logic [CNT_W-1:0]     cmp_act [NUM_CMP];
  logic [CNT_W-1:0]     cmp_nxt [NUM_CMP];
  logic [NUM_CMP-1:0]   pwm_q;

  assign mode_wr  = wr_en && (wr_sel == SEL_MODE);
  assign prd_wr   = wr_en && (wr_sel == SEL_PRD);
  assign mode_new = decode_mode(wr_data[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= CM_UP;
      shen_q <= '1;
    end else begin
      if (mode_wr) mode_q <= mode_new;
      if (wr_en && (wr_sel == SEL_SHEN)) shen_q <= wr_data[NUM_CMP-1:0];
    end
  end

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk          (clk),
    .rst          (rst),
    .tick         (cnt_en),
    .restart      (mode_wr),
    .mode         (mode_q),
    .restart_mode (mode_new),
    .prd_act      (prd_act),
    .prd_nxt      (prd_nxt),
    .cnt          (cnt_q),
    .load_pt      (load_pt)
  );

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL(RST_PRD)) u_prd (
    .clk       (clk),
    .rst       (rst),
    .wr        (prd_wr),
    .wr_data   (wr_data),
    .shadow_en (1'b1),
    .load      (load_pt),
    .active    (prd_act),
    .nxt       (prd_nxt)
  );

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_ch
    logic cmp_wr;
    assign cmp_wr = wr_en && (wr_sel == (SEL_CMPA + SEL_W'(gi)));

    pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_cmp (
      .clk       (clk),
      .rst       (rst),
      .wr        (cmp_wr),
      .wr_data   (wr_data),
      .shadow_en (shen_q[gi]),
      .load      (load_pt),
      .active    (cmp_act[gi]),
      .nxt       (cmp_nxt[gi])
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
      .clk  (clk),
      .rst  (rst),
      .tick (cnt_en),
      .mode (mode_q),
      .cnt  (cnt_q),
      .cmp  (cmp_nxt[gi]),
      .prd  (prd_nxt),
      .pwm  (pwm_q[gi])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];

endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cmp_a_nxt,
  input logic             load_pt,
  input cnt_mode_e        mode,
  input logic [1:0]       shen
);

  logic mode_wr;
  assign mode_wr = wr_en && (wr_sel == SEL_MODE);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt == '0 && !pwm_a && !pwm_b && mode == CM_UP && shen == 2'b11));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (mode != CM_DOWN) |-> (cnt <= prd_act));

  assert_force_low_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cmp_a_nxt == '0) |=> !pwm_a);

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (shen[0] && !load_pt) |=> $stable(cmp_a));

  assert_immediate_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CMPA && !shen[0]) |=> (cmp_a == $past(wr_data)));

  assert_prd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !load_pt |=> $stable(prd_act));

  assert_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !mode_wr) |=> ($stable(cnt) && $stable(pwm_a) && $stable(pwm_b)));

endmodule

bind pwm_shadow_gen pwm_shadow_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en    (cnt_en),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b),
  .cnt       (cnt_q),
  .prd_act   (prd_act),
  .cmp_a     (cmp_act[0]),
  .cmp_a_nxt (cmp_nxt[0]),
  .load_pt   (load_pt),
  .mode      (mode_q),
  .shen      (shen_q)
);

// File: tb/sim_pwm_shadow_gen.sv
module sim_pwm_shadow_gen;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         cnt_en;
  logic         wr_en;
  logic [2:0]   wr_sel;
  logic [W-1:0] wr_data;
  logic         pwm_a;
  logic         pwm_b;

  int n_total = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pwm_shadow_gen #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns one falling edge later
  task automatic reg_wr(input logic [2:0] s, input int d);
    wr_en = 1'b1; wr_sel = s; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int ha, output int hb,
                         output int a_only, output int b_only);
    ha = 0; hb = 0; a_only = 0; b_only = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_a) ha++;
      if (pwm_b) hb++;
      if (pwm_a && !pwm_b) a_only++;
      if (pwm_b && !pwm_a) b_only++;
    end
  endtask

  task automatic wait_fall_a();
    logic prev;
    prev = pwm_a;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (prev && !pwm_a) break;
      prev = pwm_a;
    end
  endtask

  task automatic t_reset();
    int ha, hb, ao, bo;
    chk(!pwm_a && !pwm_b, "R1 outputs low in reset", int'(pwm_a) + int'(pwm_b), 0);
    rst = 1'b0;
    measure(20, ha, hb, ao, bo);
    chk(ha == 0 && hb == 0, "R1 outputs stay low with reset settings", ha + hb, 0);
  endtask

  task automatic t_up();
    int ha, hb, ao, bo;
    reg_wr(3'd0, 9); reg_wr(3'd1, 4); reg_wr(3'd2, 7);
    settle(40);
    measure(10, ha, hb, ao, bo);
    chk(ha == 4, "R2 up-count duty A", ha, 4);
    chk(hb == 7, "R2 up-count duty B", hb, 7);
    chk(ao == 0, "R2 edges aligned at period start", ao, 0);
  endtask

  task automatic t_shadow();
    int ha, hb, ao, bo, hi;
    reg_wr(3'd1, 2);
    settle(30);
    wait_fall_a();
    reg_wr(3'd1, 6);
    hi = int'(pwm_a);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (pwm_a) hi++;
    end
    chk(hi == 0, "R6 buffered write held until load point", hi, 0);
    settle(30);
    measure(10, ha, hb, ao, bo);
    chk(ha == 6, "R6 buffered value applied next period", ha, 6);
  endtask

  task automatic t_immediate();
    int hi;
    reg_wr(3'd4, 2);
    settle(25);
    wait_fall_a();
    reg_wr(3'd1, 9);
    hi = int'(pwm_a);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (pwm_a) hi++;
    end
    chk(hi >= 1, "R7 R8 unbuffered A changes mid-period", hi, 2);
  endtask

  task automatic t_last_wins();
    int ha, hb, ao, bo;
    reg_wr(3'd4, 3);
    cnt_en = 1'b0;
    reg_wr(3'd1, 3); reg_wr(3'd1, 5); reg_wr(3'd1, 7);
    cnt_en = 1'b1;
    settle(30);
    measure(10, ha, hb, ao, bo);
    chk(ha == 7, "R9 last buffered write wins", ha, 7);
  endtask

  task automatic t_clk_en();
    int hold;
    for (int i = 0; i < 40; i++) begin
      if (pwm_a) break;
      @(negedge clk);
    end
    cnt_en = 1'b0;
    hold = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pwm_a) hold++;
    end
    chk(hold == 10, "R11 output frozen while cnt_en low", hold, 10);
    cnt_en = 1'b1;
  endtask

  task automatic t_force();
    int ha, hb, ao, bo;
    reg_wr(3'd1, 0); reg_wr(3'd2, 9);
    settle(40);
    measure(10, ha, hb, ao, bo);
    chk(ha == 0, "R5 compare zero gives 0% duty", ha, 0);
    chk(hb == 10, "R5 compare equal period gives 100% duty", hb, 10);
    reg_wr(3'd2, 15);
    settle(40);
    measure(10, ha, hb, ao, bo);
    chk(hb == 10, "R5 compare above period gives 100% duty", hb, 10);
  endtask

  task automatic t_period();
    int ha, hb, ao, bo;
    reg_wr(3'd0, 19); reg_wr(3'd1, 5);
    settle(60);
    measure(20, ha, hb, ao, bo);
    chk(ha == 5, "R10 new period applied", ha, 5);
  endtask

  task automatic t_down();
    int ha, hb, ao, bo;
    reg_wr(3'd0, 9); reg_wr(3'd1, 4); reg_wr(3'd2, 7);
    reg_wr(3'd3, 1);
    settle(60);
    measure(10, ha, hb, ao, bo);
    chk(ha == 4, "R3 down-count duty A", ha, 4);
    chk(hb == 7, "R3 R12 down-count duty B", hb, 7);
    chk(ao == 0, "R3 falling edges aligned", ao, 0);
  endtask

  task automatic t_updn();
    int ha, hb, ao, bo;
    reg_wr(3'd0, 10); reg_wr(3'd1, 4); reg_wr(3'd2, 8);
    reg_wr(3'd3, 3);
    settle(80);
    measure(20, ha, hb, ao, bo);
    chk(ha == 13, "R4 up-down duty A", ha, 13);
    chk(hb == 5, "R4 R12 up-down duty B", hb, 5);
    chk(bo == 0, "R4 pulses centred", bo, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst = 1'b1; cnt_en = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    t_reset();
    t_up();
    t_shadow();
    t_immediate();
    t_last_wins();
    t_clk_en();
    t_force();
    t_period();
    t_down();
    t_updn();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule